// File: doc/BRIEF.md
# Phased External Bus Timing Controller

This block sits between a soft 8-bit processor core and an external asynchronous peripheral bus. It runs on a fast system clock and divides that clock with a free-running counter. The top bit of the counter is the external bus phase clock. The block also makes a one-cycle CPU clock-enable pulse. The position of that pulse inside the phase cycle is a parameter. It sets how many system clocks the address, data and read/write lines stay unchanged after the phase falls, which is the address hold time.

On the read side, the block samples the external data pins once per bus cycle, at the phase falling edge, inside the system clock domain. The CPU reads this registered copy, never the live pins. A fixed-priority selector gives the on-chip sources precedence and falls back to the captured bus byte when no on-chip source is selected. On the write side, the block drives the external data bus only while the CPU writes and the phase is high.

Top module: `ebus_phase_ctrl`

## Requirements
- R1: While rst_n is low, bus_phase, cpu_clken and ext_doe are 0, and cpu_rdata reads 0 when no on-chip select is active.
- R2: After reset, the divider counter advances by one on every clock edge and wraps at 2^CLKEN_BITS. bus_phase is its top bit, so it is low for the first half of each period and high for the second half. The period is 16 clocks with the defaults.
- R3: cpu_clken is a single-cycle pulse, high exactly once per bus phase period.
- R4: cpu_clken is high in the cycle where the counter reads (CMP_VAL+1) modulo 2^CLKEN_BITS. With CMP_VAL = 0 this is the second cycle after the phase falls. With CMP_VAL at all ones it is the first cycle after the phase falls.
- R5: The captured bus byte takes the value of ext_din at the clock edge where bus_phase goes from 1 to 0. It keeps that value until the next such edge, whatever ext_din does in between.
- R6: cpu_rdata takes onchip_rdata slice i (bits i*8+7..i*8) for the lowest index i whose onchip_sel bit is set. The index order is 0 = RAM, 1 = ROM, 2 = serial, 3 = parallel I/O. When no select is set, cpu_rdata is the captured bus byte.
- R7: ext_doe is 1 only while cpu_we is 1 and bus_phase is 1. ext_dout always equals cpu_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_phase | output | 1 | External bus phase clock (top bit of the divider counter) |
| cpu_clken | output | 1 | One-cycle CPU clock-enable pulse |
| cpu_we | input | 1 | CPU write cycle indicator |
| cpu_wdata | input | 8 | CPU write data |
| ext_din | input | 8 | External data bus, as read from the pins |
| ext_dout | output | 8 | External data bus, value to drive |
| ext_doe | output | 1 | External data bus output enable |
| onchip_sel | input | 4 | On-chip source selects, bit 0 has the highest priority |
| onchip_rdata | input | 32 | On-chip source read data, 8 bits per source |
| cpu_rdata | output | 8 | Read data to the CPU |

## Verification
The phase and enable outputs are compared every cycle against a counter kept by the bench. One instance uses compare value 0 and a second uses all ones, which separates an off-by-one in the pulse position from a wrong comparison variant. For the capture path, a byte is placed on the pins only in the last phase-high cycle, and then overwritten with its complement and with a third pattern. A capture at the wrong edge, or a read path that uses the live pins, then shows up as the wrong byte. The selector is tried with single, overlapping and empty select sets, which tells strict priority apart from other orderings. The write enable is swept over a full period with cpu_we high and with it low.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
   localparam int NUM_ONCHIP = 4;
   localparam int BYTE_W     = 8;

   // Priority order of on-chip read sources (lower index wins)
   typedef enum logic [1:0] {
      SRC_RAM = 2'd0,
      SRC_ROM = 2'd1,
      SRC_SER = 2'd2,
      SRC_PIO = 2'd3
   } onchip_src_e;
endpackage

// File: rtl/ebus_phase_gen.sv
module ebus_phase_gen #(
   parameter int CLKEN_BITS = 4,
   parameter int CMP_VAL    = 0
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase,
   output logic fall_stb,
   output logic clken
);
   localparam int             MAXV   = (1 << CLKEN_BITS) - 1;
   localparam logic [CLKEN_BITS-1:0] CMP_V  = CMP_VAL[CLKEN_BITS-1:0];
   localparam logic [CLKEN_BITS-1:0] NEXT_V = CMP_V + 1'b1;

   generate
      if (CLKEN_BITS < 2) begin : g_bad_bits
         $error("ebus_phase_gen: CLKEN_BITS must be at least 2");
      end
      if (CMP_VAL < 0 || CMP_VAL > MAXV) begin : g_bad_cmp
         $error("ebus_phase_gen: CMP_VAL out of counter range");
      end
   endgenerate

   logic [CLKEN_BITS-1:0] cnt;
   logic                  hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   assign phase    = cnt[CLKEN_BITS-1];
   // the edge that ends the all-ones cycle is the phase falling edge
   assign fall_stb = &cnt;

   generate
      if (CMP_VAL == MAXV) begin : g_cmp_ones
         assign hit = &cnt;
      end else begin : g_cmp_eq
         assign hit = (cnt == CMP_V);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clken <= 1'b0;
      else        clken <= hit;
   end

   assert_clken_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clken |=> !clken);
   assert_clken_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clken |-> (cnt == NEXT_V));
   assert_phase_fall_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(phase) |-> (cnt == '0));
endmodule

// File: rtl/ebus_rd_capture.sv
module ebus_rd_capture #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fall_stb,
   input  logic [DW-1:0] ext_din,
   output logic [DW-1:0] cap
);
   generate
      if (DW < 1) begin : g_bad_dw
         $error("ebus_rd_capture: DW must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cap <= '0;
      else if (fall_stb) cap <= ext_din;
   end

   assert_cap_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |=> (cap == $past(ext_din)));
   assert_cap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_stb |=> $stable(cap));
endmodule

// File: rtl/ebus_rd_mux.sv
module ebus_rd_mux #(
   parameter int DW   = 8,
   parameter int NSRC = 4
) (
   input  logic [NSRC-1:0]    sel,
   input  logic [NSRC*DW-1:0] src_data,
   input  logic [DW-1:0]      fallback,
   output logic [DW-1:0]      dout
);
   generate
      if (NSRC < 1) begin : g_bad_nsrc
         $error("ebus_rd_mux: NSRC must be positive");
      end
   endgenerate

   // walk from lowest priority upward so the lowest set index wins
   always_comb begin
      dout = fallback;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (sel[i]) dout = src_data[i*DW +: DW];
      end
   end
endmodule

// File: rtl/ebus_drive_ctl.sv
module ebus_drive_ctl #(
   parameter int DW = 8
) (
   input  logic          phase,
   input  logic          cpu_we,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] ext_dout,
   output logic          ext_doe
);
   assign ext_dout = cpu_wdata;
   assign ext_doe  = cpu_we & phase;
endmodule

// File: rtl/ebus_phase_ctrl.sv
module ebus_phase_ctrl #(
   parameter int CLKEN_BITS = 4,
   parameter int CMP_VAL    = 0,
   parameter int DW         = ebus_pkg::BYTE_W,
   parameter int NSRC       = ebus_pkg::NUM_ONCHIP
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              bus_phase,
   output logic              cpu_clken,
   input  logic              cpu_we,
   input  logic [DW-1:0]     cpu_wdata,
   input  logic [DW-1:0]     ext_din,
   output logic [DW-1:0]     ext_dout,
   output logic              ext_doe,
   input  logic [NSRC-1:0]   onchip_sel,
   input  logic [NSRC*DW-1:0] onchip_rdata,
   output logic [DW-1:0]     cpu_rdata
);
   logic          fall_stb;
   logic [DW-1:0] cap;

   ebus_phase_gen #(.CLKEN_BITS(CLKEN_BITS), .CMP_VAL(CMP_VAL)) u_phase (
      .clk(clk), .rst_n(rst_n), .phase(bus_phase),
      .fall_stb(fall_stb), .clken(cpu_clken));

   ebus_rd_capture #(.DW(DW)) u_cap (
      .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb),
      .ext_din(ext_din), .cap(cap));

   ebus_rd_mux #(.DW(DW), .NSRC(NSRC)) u_mux (
      .sel(onchip_sel), .src_data(onchip_rdata),
      .fallback(cap), .dout(cpu_rdata));

   ebus_drive_ctl #(.DW(DW)) u_drv (
      .phase(bus_phase), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
      .ext_dout(ext_dout), .ext_doe(ext_doe));

   assert_top_src_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      onchip_sel[ebus_pkg::SRC_RAM] |-> (cpu_rdata == onchip_rdata[DW-1:0]));
   assert_fallback_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (onchip_sel == '0) |-> (cpu_rdata == cap));
   assert_no_drive_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_phase |-> !ext_doe);
   assert_no_drive_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_we |-> !ext_doe);
endmodule

// File: tb/ebus_phase_ctrl_tb.sv
module ebus_phase_ctrl_tb;
   localparam int PER  = 16;
   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_we = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  ext_din = '0;
   logic [3:0]  onchip_sel = '0;
   logic [31:0] onchip_rdata = 32'h44332211;
   logic        bus_phase, cpu_clken, ext_doe;
   logic [7:0]  ext_dout, cpu_rdata;
   logic        phase_m, clken_m, doe_m;
   logic [7:0]  dout_m, rdata_m;

   int checks = 0;
   int errors = 0;
   int k = 0;
   bit mon_en = 1'b0;
   bit cap_mode = 1'b0;
   logic [7:0] exp_q[$];
   logic [7:0] last_exp = '0;
   bit last_valid = 1'b0;

   always #5 clk = ~clk;

   ebus_phase_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_phase(bus_phase), .cpu_clken(cpu_clken),
      .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .ext_din(ext_din),
      .ext_dout(ext_dout), .ext_doe(ext_doe), .onchip_sel(onchip_sel),
      .onchip_rdata(onchip_rdata), .cpu_rdata(cpu_rdata));

   ebus_phase_ctrl #(.CMP_VAL(15)) u_dut_max (
      .clk(clk), .rst_n(rst_n), .bus_phase(phase_m), .cpu_clken(clken_m),
      .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .ext_din(ext_din),
      .ext_dout(dout_m), .ext_doe(doe_m), .onchip_sel(onchip_sel),
      .onchip_rdata(onchip_rdata), .cpu_rdata(rdata_m));

   always @(posedge clk) begin
      if (!rst_n) k <= 0;
      else        k <= k + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at k=%0d", req, act, exp, k);
      end
   endtask

   // monitor: phase/enable every cycle, capture scoreboard
   always @(negedge clk) begin
      #2;
      if (mon_en && rst_n) begin
         chk(bus_phase == ((k % PER) >= HALF), "R2 phase", bus_phase, (k % PER) >= HALF);
         chk(cpu_clken == ((k % PER) == 1), "R3 R4 clken cmp0", cpu_clken, (k % PER) == 1);
         chk(clken_m == ((k % PER) == 0 && k > 0), "R4 clken cmp_ones", clken_m,
             (k % PER) == 0 && k > 0);
         if (cap_mode && (k % PER) == 2 && exp_q.size() > 0) begin
            last_exp = exp_q.pop_front();
            last_valid = 1'b1;
            chk(cpu_rdata == last_exp, "R5 capture at fall", cpu_rdata, last_exp);
         end
         if (cap_mode && (k % PER) == 14 && last_valid)
            chk(cpu_rdata == last_exp, "R5 pins ignored between falls", cpu_rdata, last_exp);
      end
   end

   task automatic wait_cnt(input int c);
      @(negedge clk);
      while ((k % PER) != c) @(negedge clk);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      cpu_we = 1'b1;
      cpu_wdata = 8'h99;
      repeat (3) begin
         @(negedge clk); #2;
         chk(bus_phase == 0 && phase_m == 0, "R1 phase in reset", bus_phase, 0);
         chk(cpu_clken == 0 && clken_m == 0, "R1 clken in reset", cpu_clken, 0);
         chk(ext_doe == 0, "R1 no drive in reset", ext_doe, 0);
         chk(cpu_rdata == 0, "R1 captured byte cleared", cpu_rdata, 0);
      end
      cpu_we = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      mon_en = 1'b1;

      // capture scoreboard driver
      cap_mode = 1'b1;
      for (int i = 0; i < 6; i++) begin
         logic [7:0] v;
         v = 8'h3C + 8'(i * 8'h29);
         wait_cnt(PER - 1);
         ext_din = v;
         exp_q.push_back(v);
         @(negedge clk);
         ext_din = ~v;
         wait_cnt(HALF);
         ext_din = 8'hE7;
      end
      wait (exp_q.size() == 0);
      wait_cnt(PER - 2);
      cap_mode = 1'b0;

      // priority selection
      wait_cnt(PER - 1);
      ext_din = 8'h5A;
      @(negedge clk);
      ext_din = 8'hC3;
      @(negedge clk);
      onchip_sel = 4'b0000; #2;
      chk(cpu_rdata == 8'h5A, "R6 fallback to captured", cpu_rdata, 8'h5A);
      @(negedge clk); onchip_sel = 4'b1111; #2;
      chk(cpu_rdata == 8'h11, "R6 RAM beats all", cpu_rdata, 8'h11);
      @(negedge clk); onchip_sel = 4'b1110; #2;
      chk(cpu_rdata == 8'h22, "R6 ROM second", cpu_rdata, 8'h22);
      @(negedge clk); onchip_sel = 4'b1100; #2;
      chk(cpu_rdata == 8'h33, "R6 serial third", cpu_rdata, 8'h33);
      @(negedge clk); onchip_sel = 4'b1000; #2;
      chk(cpu_rdata == 8'h44, "R6 parallel last", cpu_rdata, 8'h44);
      @(negedge clk); onchip_sel = 4'b1010; #2;
      chk(cpu_rdata == 8'h22, "R6 sparse select", cpu_rdata, 8'h22);
      @(negedge clk); onchip_sel = 4'b0000;

      // write drive window
      cpu_wdata = 8'hA5;
      cpu_we = 1'b1;
      for (int i = 0; i < PER; i++) begin
         @(negedge clk); #2;
         chk(ext_doe == ((k % PER) >= HALF), "R7 drive while phase high", ext_doe,
             (k % PER) >= HALF);
         chk(ext_dout == 8'hA5, "R7 write data", ext_dout, 8'hA5);
      end
      cpu_we = 1'b0;
      for (int i = 0; i < PER; i++) begin
         @(negedge clk); #2;
         chk(ext_doe == 1'b0, "R7 no drive on read", ext_doe, 0);
      end

      mon_en = 1'b0;
      summary();
      $finish;
   end
endmodule